// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block gathers every interrupt condition of a single UART channel and reduces them to one interrupt status byte plus an interrupt pin. Some sources are levels that the rest of the channel holds for as long as the condition lasts: a line error, received data waiting, a receive timeout. The others are events that the block latches itself: the transmit FIFO crossing below its trigger level or going empty, a modem line change, an Xoff character seen, a special character seen, and a change of the RTS/CTS flow state. Each latched event has its own clearing rule, tied to host reads of the status register or the modem status register, or to the arrival of the next character.

The status byte names the highest-priority pending source, so host software can branch on it directly. The interrupt pin carries the OR of all enabled pending sources. A separate enable output says whether the pin is driven or left floating. If software clears every enable bit, the pin stays quiet while the status byte still reports the raw conditions for polled operation. All status and pin changes appear on the clock edge that samples the causing input.

Top module: `uart_irq_arbiter`

## Requirements
- R1: Reset, whether applied at power-up or during operation, makes `isr` read 0x01 and `irq` low.
- R2: `isr` bit 0 is 0 whenever a source is reported. The codes are:
  - line error 0x06
  - received data 0x04
  - receive timeout 0x0C
  - transmit 0x02
  - modem change 0x00
  - Xoff or special character 0x10
  - flow-state change 0x20

  A sampled input shows up on `isr` and `irq` one clock edge later.
- R3: When several sources are pending, only the highest is reported. The order, highest first, is: line error, receive, transmit, modem change, Xoff/special, flow-state change.
- R4: The line error and receive sources follow their level inputs with no latching. When `rx_timeout` is high, the receive code is 0x0C instead of 0x04.
- R5: The transmit source is latched on a rising edge of `tx_below` and again on a rising edge of `tx_empty`. It is cleared by a `rd_isr` strobe issued while `isr` reads 0x02.
- R6: Modem-change and flow-change sources are latched by `msr_delta` and `flow_chg` pulses and cleared by a `rd_msr` strobe. A set and a clear in the same cycle leave the source set.
- R7: The Xoff source is latched by `xoff_rx` and cleared by any `rd_isr` strobe, even one issued while a higher source is being reported.
- R8: The special-character source is latched by `special_rx`. It is cleared by `rd_isr` or by `rx_char`, whichever comes first.
- R9: `irq` is high when any enabled source is pending. When all `ier` bits are 0, `irq` stays low and `isr` reports the highest raw pending source.
- R10: `irq_oe` is high exactly when `oe_en` or `force_cont` is high, with no clock delay.
- R11: When at least one `ier` bit is set, a source whose enable is 0 is neither reported on `isr` nor able to raise `irq`.

  The `ier` bits map to sources as follows:
  - bit 0: receive
  - bit 1: transmit
  - bit 2: line error
  - bit 3: modem change
  - bit 4: Xoff/special
  - bit 5: flow-state change

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 6 | Per-source enable bits (mapping in R11) |
| lsr_err | input | 1 | Line error level |
| rx_ready | input | 1 | Receive data ready level |
| rx_timeout | input | 1 | Receive timeout level |
| tx_below | input | 1 | Transmit FIFO below trigger level |
| tx_empty | input | 1 | Transmit FIFO empty |
| msr_delta | input | 1 | Modem line change pulse |
| xoff_rx | input | 1 | Xoff character received pulse |
| special_rx | input | 1 | Special character received pulse |
| rx_char | input | 1 | Any character received pulse |
| flow_chg | input | 1 | RTS/CTS flow-state change pulse |
| rd_isr | input | 1 | Host read strobe of the status register |
| rd_msr | input | 1 | Host read strobe of the modem status register |
| oe_en | input | 1 | Software pin output enable |
| force_cont | input | 1 | Select input forcing the pin always driven |
| isr | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The hardest situations to reach are the ones where a clearing rule meets a hidden source. One case is a status read that removes an Xoff event while a modem change masks it. Another is a set pulse and a clear strobe landing in the same cycle. The vector table builds these up over several cycles: it stacks a lower source under a higher one, strobes a read, then removes the higher source to reveal whether the lower one survived. The same method shows that a transmit event is cleared only by a status read made while that event is the one reported.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC  = 6;
    localparam int ISR_W = 8;

    // source index, lower index wins
    localparam int S_LINE  = 0;
    localparam int S_RX    = 1;
    localparam int S_TX    = 2;
    localparam int S_MODEM = 3;
    localparam int S_XSPC  = 4;
    localparam int S_FLOW  = 5;

    localparam logic [ISR_W-1:0] CODE_IDLE  = 8'h01;
    localparam logic [ISR_W-1:0] CODE_LINE  = 8'h06;
    localparam logic [ISR_W-1:0] CODE_RXD   = 8'h04;
    localparam logic [ISR_W-1:0] CODE_RXTO  = 8'h0C;
    localparam logic [ISR_W-1:0] CODE_TX    = 8'h02;
    localparam logic [ISR_W-1:0] CODE_MODEM = 8'h00;
    localparam logic [ISR_W-1:0] CODE_XSPC  = 8'h10;
    localparam logic [ISR_W-1:0] CODE_FLOW  = 8'h20;

    function automatic logic [ISR_W-1:0] src_code(input int idx, input logic rx_to);
        case (idx)
            S_LINE:  src_code = CODE_LINE;
            S_RX:    src_code = rx_to ? CODE_RXTO : CODE_RXD;
            S_TX:    src_code = CODE_TX;
            S_MODEM: src_code = CODE_MODEM;
            S_XSPC:  src_code = CODE_XSPC;
            default: src_code = CODE_FLOW;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_capture.sv
module uart_irq_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_below,
    input  logic tx_empty,
    input  logic msr_delta,
    input  logic xoff_rx,
    input  logic special_rx,
    input  logic rx_char,
    input  logic flow_chg,
    input  logic rd_isr,
    input  logic rd_msr,
    input  logic tx_shown,
    output logic tx_n,
    output logic modem_n,
    output logic xspc_n,
    output logic flow_n
);
    typedef struct packed {
        logic tx;
        logic modem;
        logic xoff;
        logic spc;
        logic flow;
        logic txb_prev;
        logic txe_prev;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        cap_d.txb_prev = tx_below;
        cap_d.txe_prev = tx_empty;

        // clears first, so that a set in the same cycle wins
        if (rd_isr && tx_shown) cap_d.tx = 1'b0;
        if ((tx_below && !cap_q.txb_prev) || (tx_empty && !cap_q.txe_prev))
            cap_d.tx = 1'b1;

        if (rd_msr) begin
            cap_d.modem = 1'b0;
            cap_d.flow  = 1'b0;
        end
        if (msr_delta) cap_d.modem = 1'b1;
        if (flow_chg)  cap_d.flow  = 1'b1;

        if (rd_isr)  cap_d.xoff = 1'b0;
        if (xoff_rx) cap_d.xoff = 1'b1;

        if (rd_isr || rx_char) cap_d.spc = 1'b0;
        if (special_rx)        cap_d.spc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign tx_n    = cap_d.tx;
    assign modem_n = cap_d.modem;
    assign xspc_n  = cap_d.xoff | cap_d.spc;
    assign flow_n  = cap_d.flow;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    input  logic             rx_to,
    output logic [ISR_W-1:0] code
);
    always_comb begin
        code = CODE_IDLE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) code = src_code(i, rx_to);
        end
    end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  ier,
    input  logic             lsr_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             tx_below,
    input  logic             tx_empty,
    input  logic             msr_delta,
    input  logic             xoff_rx,
    input  logic             special_rx,
    input  logic             rx_char,
    input  logic             flow_chg,
    input  logic             rd_isr,
    input  logic             rd_msr,
    input  logic             oe_en,
    input  logic             force_cont,
    output logic [ISR_W-1:0] isr,
    output logic             irq,
    output logic             irq_oe
);
    typedef struct packed {
        logic [ISR_W-1:0] isr;
        logic             irq;
    } out_t;

    out_t out_d, out_q;

    logic             tx_n, modem_n, xspc_n, flow_n;
    logic [NSRC-1:0]  raw, en, armed, shown;
    logic [ISR_W-1:0] code;

    uart_irq_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_below   (tx_below),
        .tx_empty   (tx_empty),
        .msr_delta  (msr_delta),
        .xoff_rx    (xoff_rx),
        .special_rx (special_rx),
        .rx_char    (rx_char),
        .flow_chg   (flow_chg),
        .rd_isr     (rd_isr),
        .rd_msr     (rd_msr),
        .tx_shown   (out_q.isr == CODE_TX),
        .tx_n       (tx_n),
        .modem_n    (modem_n),
        .xspc_n     (xspc_n),
        .flow_n     (flow_n)
    );

    always_comb begin
        raw          = '0;
        raw[S_LINE]  = lsr_err;
        raw[S_RX]    = rx_ready | rx_timeout;
        raw[S_TX]    = tx_n;
        raw[S_MODEM] = modem_n;
        raw[S_XSPC]  = xspc_n;
        raw[S_FLOW]  = flow_n;

        en          = '0;
        en[S_RX]    = ier[0];
        en[S_TX]    = ier[1];
        en[S_LINE]  = ier[2];
        en[S_MODEM] = ier[3];
        en[S_XSPC]  = ier[4];
        en[S_FLOW]  = ier[5];

        armed = raw & en;
        shown = (|en) ? armed : raw;
    end

    uart_irq_prio u_prio (
        .pend  (shown),
        .rx_to (rx_timeout),
        .code  (code)
    );

    always_comb begin
        out_d     = out_q;
        out_d.isr = code;
        out_d.irq = |armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.isr <= CODE_IDLE;
            out_q.irq <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign isr    = out_q.isr;
    assign irq    = out_q.irq;
    assign irq_oe = oe_en | force_cont;
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ier,
    input logic       lsr_err,
    input logic       msr_delta,
    input logic       flow_chg,
    input logic       xoff_rx,
    input logic       special_rx,
    input logic       rd_isr,
    input logic       rd_msr,
    input logic [7:0] isr,
    input logic       irq
);
    a_r2_pending_bit: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !isr[0]);

    a_r3_line_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_err && ier[2]) |=> (isr == 8'h06));

    a_r6_msr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && !msr_delta && !flow_chg) |=> (isr != 8'h00 && isr != 8'h20));

    a_r7_isr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr && !xoff_rx && !special_rx) |=> (isr != 8'h10));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ier) != 6'd0));
endmodule

bind uart_irq_arbiter uart_irq_checker u_chk (.*);

// File: tb/sim_uart_irq_arbiter.sv
module sim_uart_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ier = 6'h3F;
    logic       lsr_err = 0, rx_ready = 0, rx_timeout = 0, tx_below = 0, tx_empty = 0;
    logic       msr_delta = 0, xoff_rx = 0, special_rx = 0, rx_char = 0, flow_chg = 0;
    logic       rd_isr = 0, rd_msr = 0, oe_en = 0, force_cont = 0;
    logic [7:0] isr;
    logic       irq, irq_oe;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_arbiter u0 (.*);

    // lvl: lsr,rxr,rxto,txb,txe   pul: msr,xoff,spc,rxc,flow,rdi,rdm
    typedef struct packed {
        logic [5:0] ier;
        logic [4:0] lvl;
        logic [6:0] pul;
        logic [7:0] eisr;
        logic       eirq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{6'h3F, 5'b00000, 7'b0000000, 8'h01, 1'b0, 4'd1},  // R1 idle
        '{6'h3F, 5'b10000, 7'b0000000, 8'h06, 1'b1, 4'd4},  // R4 line
        '{6'h3F, 5'b11000, 7'b0000000, 8'h06, 1'b1, 4'd3},  // R3 line over rx
        '{6'h3F, 5'b01000, 7'b0000000, 8'h04, 1'b1, 4'd4},  // R4 rx
        '{6'h3F, 5'b01100, 7'b0000000, 8'h0C, 1'b1, 4'd4},  // R4 timeout
        '{6'h3F, 5'b00000, 7'b0000000, 8'h01, 1'b0, 4'd4},  // R4 level gone
        '{6'h3F, 5'b00010, 7'b0000000, 8'h02, 1'b1, 4'd5},  // R5 below trigger
        '{6'h3F, 5'b00010, 7'b0000010, 8'h01, 1'b0, 4'd5},  // R5 read clears
        '{6'h3F, 5'b00011, 7'b0000000, 8'h02, 1'b1, 4'd5},  // R5 empty fires again
        '{6'h3F, 5'b00011, 7'b0000010, 8'h01, 1'b0, 4'd5},  // R5
        '{6'h3F, 5'b00000, 7'b1000000, 8'h00, 1'b1, 4'd6},  // R6 modem, R2 code
        '{6'h3F, 5'b00000, 7'b0100000, 8'h00, 1'b1, 4'd3},  // R3 xoff hidden
        '{6'h3F, 5'b00000, 7'b0000001, 8'h10, 1'b1, 4'd6},  // R6 msr read
        '{6'h3F, 5'b00000, 7'b0000010, 8'h01, 1'b0, 4'd7},  // R7
        '{6'h3F, 5'b00000, 7'b0010000, 8'h10, 1'b1, 4'd8},  // R8 special
        '{6'h3F, 5'b00000, 7'b0001000, 8'h01, 1'b0, 4'd8},  // R8 next char
        '{6'h3F, 5'b00000, 7'b0010000, 8'h10, 1'b1, 4'd8},  // R8
        '{6'h3F, 5'b00000, 7'b0000010, 8'h01, 1'b0, 4'd8},  // R8 isr read
        '{6'h3F, 5'b00000, 7'b0000100, 8'h20, 1'b1, 4'd6},  // R6 flow
        '{6'h3F, 5'b00000, 7'b0000101, 8'h20, 1'b1, 4'd6},  // R6 set wins
        '{6'h3F, 5'b00000, 7'b0000001, 8'h01, 1'b0, 4'd6},  // R6
        '{6'h00, 5'b01000, 7'b0000000, 8'h04, 1'b0, 4'd9},  // R9 polled
        '{6'h02, 5'b01000, 7'b0000000, 8'h01, 1'b0, 4'd11}, // R11 rx masked
        '{6'h02, 5'b01010, 7'b0000000, 8'h02, 1'b1, 4'd11}, // R11 tx enabled
        '{6'h02, 5'b01010, 7'b0000010, 8'h01, 1'b0, 4'd11}, // R11
        '{6'h3F, 5'b00000, 7'b1100000, 8'h00, 1'b1, 4'd7},  // R7 xoff under modem
        '{6'h3F, 5'b00000, 7'b0000010, 8'h00, 1'b1, 4'd7},  // R7 read hits xoff
        '{6'h3F, 5'b00000, 7'b0000001, 8'h01, 1'b0, 4'd7}   // R7 xoff gone
    };

    task automatic check(input string req, input logic [7:0] a, input logic [7:0] e);
        tests++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, a, e);
        end
    endtask

    task automatic drive(input vec_t v);
        ier = v.ier;
        {lsr_err, rx_ready, rx_timeout, tx_below, tx_empty} = v.lvl;
        {msr_delta, xoff_rx, special_rx, rx_char, flow_chg, rd_isr, rd_msr} = v.pul;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 isr", isr, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d isr v%0d", VEC[i].req, i), isr, VEC[i].eisr);
            check($sformatf("R%0d irq v%0d", VEC[i].req, i), {7'd0, irq}, {7'd0, VEC[i].eirq});
        end
        drive('0);
        ier = 6'h3F;
        // R10 pin drive enable, all four combinations
        for (int k = 0; k < 4; k++) begin
            {oe_en, force_cont} = k[1:0];
            #1;
            check("R10 irq_oe", {7'd0, irq_oe}, {7'd0, (k != 0)});
        end
        // R1 reset during operation
        @(negedge clk);
        msr_delta = 1'b1;
        @(negedge clk);
        msr_delta = 1'b0;
        check("R6 pre-reset", isr, 8'h00);
        rst_n = 1'b0;
        #1;
        check("R1 mid isr", isr, 8'h01);
        check("R1 mid irq", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", isr, 8'h01);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule